// File: doc/BRIEF.md
# Single-Conversion ADC Host Sequencer

This block is the host side of a serial link to a sigma-delta converter. It runs one conversion in single-shot mode and returns the result. On a start pulse it selects the converter, shifts out the mode-register write that starts one conversion, and then keeps the select low. While the converter works, the block leaves the serial clock parked high and holds the data-out line low. The converter's data/ready line falling low marks the end of the conversion. The block then sends the read-data command and clocks in a 16- or 24-bit result. The result comes back on a one-cycle valid strobe.

A second command input runs the interface recovery sequence. This is a frame of 32 ones, followed by a guard wait so that the converter can settle before it is addressed again. After reset the block stays busy for a power-up interval before it accepts any command. If the ready indication never arrives, a timeout abandons the wait and raises an error flag. All intervals and the serial clock half-period are set by parameters and counted in system clocks.

States: `ST_BOOT` (power-up wait), `ST_IDLE`, `ST_WR_MODE` (24-bit mode write), `ST_WAIT_RDY` (waiting for the ready low), `ST_RD_CMD` (8-bit read command), `ST_RD_DATA` (result shift-in), `ST_DONE` (valid strobe), `ST_IF_RESET` (32 ones), `ST_GUARD` (post-recovery wait). Transitions:
- `BOOT→IDLE` when the power-up timer expires.
- `IDLE→IF_RESET` on a recovery request.
- `IDLE→WR_MODE` on a start.
- `WR_MODE→WAIT_RDY` at the end of the frame.
- `WAIT_RDY→RD_CMD` when the ready line goes low.
- `WAIT_RDY→IDLE` when the timer expires.
- `RD_CMD→RD_DATA`, `RD_DATA→DONE` and `IF_RESET→GUARD` at the end of each frame.
- `DONE→IDLE` unconditionally.
- `GUARD→IDLE` when the guard timer expires.

Top module: `sdadc_oneshot_host`

## Requirements
- R1: After reset, `busy_o` stays high and the chip select stays high for `PWRUP_CYC` cycles. Start and recovery requests made during this time are ignored.
- R2: A start accepted in idle lowers the chip select and shifts out 24 bits MSB first: byte 0x08 and then the mode word 0x200A. Data-out changes while SCLK is low, and the converter samples it on the SCLK rising edge.
- R3: After the mode write, the chip select stays low, SCLK stays high and data-out stays low. No SCLK edge occurs until the data/ready input is sampled low.
- R4: Once the ready input is low, the block shifts out the byte 0x58 without releasing the chip select. It then clocks in the result MSB first on SCLK rising edges and holds data-out low.
- R5: The width is taken from `width24_i` when the start is accepted (1 gives 24 bits, 0 gives 16 bits). Later changes to `width24_i` have no effect on that read. A 16-bit result is zero-extended in `result_o`.
- R6: `valid_o` is high for exactly one cycle with the result on `result_o`. `busy_o` is high during that cycle and low in the next one.
- R7: Start and recovery requests made while `busy_o` is high are ignored.
- R8: If the ready input is not seen low within `TIMEOUT_CYC` cycles of the mode write ending, the block raises the chip select and returns to idle with `timeout_o` set and no valid strobe. The next accepted command clears `timeout_o`.
- R9: A recovery request shifts out exactly 32 ones in one chip-select frame. `busy_o` then stays high for `GUARD_CYC`+1 cycles after the chip select rises.
- R10: If a start and a recovery request arrive in the same idle cycle, the recovery request wins.
- R11: Whenever `busy_o` is low, the chip select is high, SCLK is high and data-out is low.
- R12: Every SCLK low phase inside a frame lasts exactly `CLK_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion and read |
| width24_i | input | 1 | Result width select, 1 = 24 bits, 0 = 16 bits |
| ifreset_i | input | 1 | Request the 32-ones interface recovery |
| busy_o | output | 1 | Sequencer is not idle |
| valid_o | output | 1 | One-cycle strobe, result_o holds a new result |
| result_o | output | 24 | Last conversion result, zero-extended for 16 bits |
| timeout_o | output | 1 | Last conversion wait timed out |
| spi_sclk_o | output | 1 | Serial clock, idles high |
| spi_cs_n_o | output | 1 | Active-low converter select |
| spi_mosi_o | output | 1 | Serial data to the converter |
| spi_miso_i | input | 1 | Serial data and ready indication from the converter |

## Verification
A wrong state code shows at the pins within one system clock. One symptom is a chip select low or an SCLK toggling while the block reports idle. Another is data-out high during the ready wait, or clock edges reaching the converter before its ready line has fallen. A mis-sequenced frame shows at the end of the transfer as a wrong bit count or a wrong command byte in the converter model's capture log. A wrong latched width or a mis-ordered shift shows as a wrong value when the result strobe fires. A wrong timer load shows as a busy interval of the wrong length after recovery or reset.

// File: rtl/sdadc_host_pkg.sv
package sdadc_host_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_IDLE,
        ST_WR_MODE,
        ST_WAIT_RDY,
        ST_RD_CMD,
        ST_RD_DATA,
        ST_DONE,
        ST_IF_RESET,
        ST_GUARD
    } host_state_e;

    localparam int          FRAME_W      = 32;
    localparam int          RES_W        = 24;
    localparam logic [7:0]  CMD_WR_MODE  = 8'h08;
    localparam logic [15:0] MODE_ONESHOT = 16'h200A;
    localparam logic [7:0]  CMD_RD_DATA  = 8'h58;
    localparam int          MODE_BITS    = 24;
    localparam int          CMD_BITS     = 8;
    localparam int          RECOVER_BITS = 32;

endpackage

// File: rtl/sdadc_bit_engine.sv
module sdadc_bit_engine #(
    parameter int DIV     = 4,
    parameter int FRAME_W = 32,
    parameter int RX_W    = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go_i,
    input  logic [$clog2(FRAME_W+1)-1:0] nbits_i,
    input  logic [FRAME_W-1:0]         tx_i,
    input  logic                       miso_i,
    output logic                       sclk_o,
    output logic                       mosi_o,
    output logic [RX_W-1:0]            rx_o,
    output logic                       done_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic               run_q;
    logic [DIV_W-1:0]   div_q;
    logic [CNT_W-1:0]   left_q;
    logic [FRAME_W-1:0] sh_q;
    logic               half_end;

    assign half_end = run_q && (div_q == DIV_W'(DIV - 1));
    assign done_o   = half_end && sclk_o && (left_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            div_q  <= '0;
            left_q <= '0;
            sh_q   <= '0;
            rx_o   <= '0;
            sclk_o <= 1'b1;
            mosi_o <= 1'b0;
        end else if (go_i) begin
            run_q  <= 1'b1;
            div_q  <= '0;
            left_q <= nbits_i;
            sh_q   <= tx_i << 1;
            rx_o   <= '0;
            sclk_o <= 1'b0;
            mosi_o <= tx_i[FRAME_W-1];
        end else if (half_end) begin
            div_q <= '0;
            if (!sclk_o) begin
                sclk_o <= 1'b1;
                rx_o   <= {rx_o[RX_W-2:0], miso_i};
            end else if (left_q == CNT_W'(1)) begin
                run_q  <= 1'b0;
                mosi_o <= 1'b0;
            end else begin
                sclk_o <= 1'b0;
                mosi_o <= sh_q[FRAME_W-1];
                sh_q   <= sh_q << 1;
                left_q <= left_q - CNT_W'(1);
            end
        end else if (run_q) begin
            div_q <= div_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/sdadc_wait_timer.sv
module sdadc_wait_timer #(
    parameter int W    = 20,
    parameter int INIT = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(INIT);
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sdadc_oneshot_host.sv
module sdadc_oneshot_host
    import sdadc_host_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int PWRUP_CYC   = 100000,
    parameter int GUARD_CYC   = 50000,
    parameter int TIMEOUT_CYC = 2000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        width24_i,
    input  logic        ifreset_i,
    output logic        busy_o,
    output logic        valid_o,
    output logic [23:0] result_o,
    output logic        timeout_o,
    output logic        spi_sclk_o,
    output logic        spi_cs_n_o,
    output logic        spi_mosi_o,
    input  logic        spi_miso_i
);
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int MAX_A   = (PWRUP_CYC > GUARD_CYC) ? PWRUP_CYC : GUARD_CYC;
    localparam int TMR_MAX = (MAX_A > TIMEOUT_CYC) ? MAX_A : TIMEOUT_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    host_state_e        state_q, state_d;
    logic               eng_go, eng_done;
    logic [CNT_W-1:0]   eng_nbits;
    logic [FRAME_W-1:0] eng_tx;
    logic [RES_W-1:0]   eng_rx;
    logic               tmr_load, tmr_expired;
    logic [TMR_W-1:0]   tmr_val;
    logic               wide_q;

    sdadc_bit_engine #(
        .DIV     (CLK_DIV),
        .FRAME_W (FRAME_W),
        .RX_W    (RES_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (eng_go),
        .nbits_i (eng_nbits),
        .tx_i    (eng_tx),
        .miso_i  (spi_miso_i),
        .sclk_o  (spi_sclk_o),
        .mosi_o  (spi_mosi_o),
        .rx_o    (eng_rx),
        .done_o  (eng_done)
    );

    sdadc_wait_timer #(
        .W    (TMR_W),
        .INIT (PWRUP_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Next state and frame launch
    always_comb begin
        state_d   = state_q;
        eng_go    = 1'b0;
        eng_tx    = '0;
        eng_nbits = '0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            ST_BOOT: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (ifreset_i) begin
                    state_d   = ST_IF_RESET;
                    eng_go    = 1'b1;
                    eng_tx    = '1;
                    eng_nbits = CNT_W'(RECOVER_BITS);
                end else if (start_i) begin
                    state_d   = ST_WR_MODE;
                    eng_go    = 1'b1;
                    eng_tx    = {CMD_WR_MODE, MODE_ONESHOT, 8'h00};
                    eng_nbits = CNT_W'(MODE_BITS);
                end
            end
            ST_WR_MODE: begin
                if (eng_done) begin
                    state_d  = ST_WAIT_RDY;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(TIMEOUT_CYC);
                end
            end
            ST_WAIT_RDY: begin
                if (!spi_miso_i) begin
                    state_d   = ST_RD_CMD;
                    eng_go    = 1'b1;
                    eng_tx    = {CMD_RD_DATA, 24'h000000};
                    eng_nbits = CNT_W'(CMD_BITS);
                end else if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_CMD: begin
                if (eng_done) begin
                    state_d   = ST_RD_DATA;
                    eng_go    = 1'b1;
                    eng_nbits = wide_q ? CNT_W'(24) : CNT_W'(16);
                end
            end
            ST_RD_DATA: begin
                if (eng_done) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            ST_IF_RESET: begin
                if (eng_done) begin
                    state_d  = ST_GUARD;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(GUARD_CYC);
                end
            end
            ST_GUARD: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spi_cs_n_o <= 1'b1;
            valid_o    <= 1'b0;
            result_o   <= '0;
            timeout_o  <= 1'b0;
            wide_q     <= 1'b0;
        end else begin
            spi_cs_n_o <= !(state_d inside {ST_WR_MODE, ST_WAIT_RDY, ST_RD_CMD,
                                            ST_RD_DATA, ST_IF_RESET});
            valid_o    <= (state_d == ST_DONE);
            if (state_q == ST_RD_DATA && state_d == ST_DONE)
                result_o <= wide_q ? eng_rx : {8'h00, eng_rx[15:0]};
            if (state_q == ST_IDLE && state_d == ST_WR_MODE) begin
                wide_q    <= width24_i;
                timeout_o <= 1'b0;
            end
            if (state_q == ST_IDLE && state_d == ST_IF_RESET)
                timeout_o <= 1'b0;
            if (state_q == ST_WAIT_RDY && state_d == ST_IDLE)
                timeout_o <= 1'b1;
        end
    end

    assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/sdadc_host_chk.sv
module sdadc_host_chk
    import sdadc_host_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input host_state_e state_q,
    input logic        busy_o,
    input logic        valid_o,
    input logic        timeout_o,
    input logic        spi_sclk_o,
    input logic        spi_cs_n_o,
    input logic        spi_mosi_o
);
    assert_idle_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (spi_cs_n_o && spi_sclk_o && !spi_mosi_o));

    assert_wait_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RDY) |-> (!spi_cs_n_o && spi_sclk_o && !spi_mosi_o));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_valid_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> busy_o);

    assert_boot_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |-> (spi_cs_n_o && busy_o));

    assert_timeout_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !valid_o);

endmodule

bind sdadc_oneshot_host sdadc_host_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .busy_o     (busy_o),
    .valid_o    (valid_o),
    .timeout_o  (timeout_o),
    .spi_sclk_o (spi_sclk_o),
    .spi_cs_n_o (spi_cs_n_o),
    .spi_mosi_o (spi_mosi_o)
);

// File: tb/sdadc_oneshot_host_tb.sv
module sdadc_oneshot_host_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 2;
    localparam int PWRUP      = 40;
    localparam int GUARD      = 30;
    localparam int TIMEOUT    = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, width24_i = 1'b0, ifreset_i = 1'b0;
    logic busy_o, valid_o, timeout_o, spi_sclk_o, spi_cs_n_o, spi_mosi_o;
    logic [23:0] result_o;
    logic dev_miso = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdadc_oneshot_host #(
        .CLK_DIV(CLK_DIV), .PWRUP_CYC(PWRUP), .GUARD_CYC(GUARD), .TIMEOUT_CYC(TIMEOUT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .width24_i(width24_i),
        .ifreset_i(ifreset_i), .busy_o(busy_o), .valid_o(valid_o), .result_o(result_o),
        .timeout_o(timeout_o), .spi_sclk_o(spi_sclk_o), .spi_cs_n_o(spi_cs_n_o),
        .spi_mosi_o(spi_mosi_o), .spi_miso_i(dev_miso)
    );

    // Converter configuration, driven by the stimulus process
    logic [23:0] dev_data = '0;
    int dev_width = 24;
    bit conv_en = 1'b0;
    int conv_delay = 60;

    // Converter model and per-clock monitor state
    int frames = 0, rx_bits = 0, ones_run = 0, max_ones = 0;
    logic [63:0] rx_log = '0;
    bit waiting = 0, rdy = 0, data_phase = 0;
    int conv_cnt = 0, data_idx = 0, early_clk = 0, wait_bad = 0, lowrun = 0;
    logic sclk_prev = 1'b1, cs_prev = 1'b1;
    int mon_checks = 0, mon_fails = 0;
    int n_checks = 0, n_fail = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            sclk_prev = 1'b1; cs_prev = 1'b1; dev_miso = 1'b1;
        end else begin
            if (spi_cs_n_o) begin
                dev_miso = 1'b1; waiting = 0; rdy = 0; data_phase = 0; lowrun = 0;
            end else begin
                if (cs_prev) begin
                    frames++; rx_bits = 0; rx_log = '0; ones_run = 0; max_ones = 0;
                end
                if (spi_sclk_o && !sclk_prev) begin
                    rx_log = {rx_log[62:0], spi_mosi_o};
                    rx_bits++;
                    ones_run = spi_mosi_o ? ones_run + 1 : 0;
                    if (ones_run > max_ones) max_ones = ones_run;
                    if (rx_bits == 24 && rx_log[23:0] == 24'h08200A && conv_en) begin
                        waiting = 1; conv_cnt = conv_delay;
                    end
                    if (rx_bits == 32 && rx_log[7:0] == 8'h58 && rdy) begin
                        data_phase = 1; data_idx = dev_width;
                    end
                end
                if (!spi_sclk_o && sclk_prev) begin
                    if (waiting && !rdy) early_clk++;
                    if (data_phase && data_idx > 0) begin
                        dev_miso = dev_data[data_idx-1];
                        data_idx--;
                    end
                end
                if (waiting && !rdy) begin
                    if (spi_mosi_o || !spi_sclk_o) wait_bad++;
                    if (conv_cnt > 0) conv_cnt--;
                    if (conv_cnt == 0) begin rdy = 1; dev_miso = 1'b0; end
                end
                // R12: low-phase length
                if (!spi_sclk_o) lowrun++;
                else if (lowrun > 0) begin
                    mon_checks++;
                    if (lowrun != CLK_DIV) begin
                        mon_fails++;
                        $display("FAIL R12 sclk low phase: got %0d expected %0d", lowrun, CLK_DIV);
                    end
                    lowrun = 0;
                end
            end
            // R11: idle lines
            if (!busy_o) begin
                mon_checks++;
                if (!(spi_cs_n_o && spi_sclk_o && !spi_mosi_o)) begin
                    mon_fails++;
                    $display("FAIL R11 idle lines: got cs_n=%b sclk=%b mosi=%b expected 1 1 0",
                             spi_cs_n_o, spi_sclk_o, spi_mosi_o);
                end
            end
            sclk_prev = spi_sclk_o; cs_prev = spi_cs_n_o;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input bit w);
        start_i = 1'b1; width24_i = w;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_valid(output bit got, output logic [23:0] res);
        got = 0; res = '0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (valid_o) begin got = 1; res = result_o; break; end
        end
    endtask

    task automatic wait_cs_high();
        for (int i = 0; i < 3000; i++) begin
            if (spi_cs_n_o) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (!busy_o) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 10000) @(posedge clk);
        $display("FAIL watchdog: got hung run expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks + mon_checks + 1, n_fail + mon_fails + 1);
        $finish;
    end

    initial begin
        bit got;
        logic [23:0] res;
        int cnt;

        repeat (3) @(negedge clk);
        // R1 / R11: reset values
        check(spi_cs_n_o && spi_sclk_o && !spi_mosi_o, "R11", "reset lines",
              {spi_cs_n_o, spi_sclk_o, spi_mosi_o}, 3'b110);
        check(busy_o && !valid_o && !timeout_o, "R1", "reset busy/valid/timeout",
              {busy_o, valid_o, timeout_o}, 3'b100);
        rst_n = 1'b1;
        for (int i = 1; i <= PWRUP + 2; i++) begin
            @(negedge clk);
            if (i == 5) begin start_i = 1'b1; ifreset_i = 1'b1; end
            if (i == 6) begin start_i = 1'b0; ifreset_i = 1'b0; end
            if (i == PWRUP - 1) check(busy_o == 1'b1, "R1", "busy during power-up", busy_o, 1);
        end
        check(busy_o == 1'b0, "R1", "idle after power-up", busy_o, 0);
        check(frames == 0, "R1", "no frame during power-up", frames, 0);

        // R2 R4 R5 R6: 24-bit conversion
        dev_data = 24'hA5C3E1; dev_width = 24; conv_en = 1; conv_delay = 60;
        pulse_start(1'b1);
        wait_valid(got, res);
        check(got, "R6", "valid seen (24-bit)", got, 1);
        check(res == 24'hA5C3E1, "R4", "24-bit result", res, 24'hA5C3E1);
        check(rx_bits == 56, "R2", "bits in frame (24-bit)", rx_bits, 56);
        check(rx_log[55:32] == 24'h08200A, "R2", "mode write", rx_log[55:32], 24'h08200A);
        check(rx_log[31:24] == 8'h58, "R4", "read command", rx_log[31:24], 8'h58);
        check(rx_log[23:0] == 24'h0, "R4", "data-out low during read", rx_log[23:0], 0);
        check(frames == 1, "R4", "single select frame", frames, 1);
        @(negedge clk);
        check(!valid_o && !busy_o, "R6", "valid one cycle, busy drops",
              {valid_o, busy_o}, 2'b00);

        // R5: 16-bit read, width change after start ignored
        dev_data = 24'h00BEEF; dev_width = 16; conv_delay = 90;
        pulse_start(1'b0);
        width24_i = 1'b1;
        wait_valid(got, res);
        width24_i = 1'b0;
        check(got && res == 24'h00BEEF, "R5", "16-bit result zero-extended", res, 24'h00BEEF);
        check(rx_bits == 48, "R5", "bits in frame (16-bit)", rx_bits, 48);
        wait_idle();

        // R7: requests while busy ignored
        dev_data = 24'h5A0F3C; dev_width = 24; conv_delay = 150;
        cnt = frames;
        pulse_start(1'b1);
        repeat (120) @(negedge clk);
        start_i = 1'b1; ifreset_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; ifreset_i = 1'b0;
        wait_valid(got, res);
        check(got && res == 24'h5A0F3C, "R7", "result after ignored requests", res, 24'h5A0F3C);
        check(frames == cnt + 1 && max_ones < 32, "R7", "no extra frame",
              frames - cnt, 1);
        check(early_clk == 0 && wait_bad == 0, "R3", "quiet wait for ready",
              early_clk + wait_bad, 0);
        wait_idle();

        // R8: timeout
        conv_en = 0;
        pulse_start(1'b1);
        repeat (MODE_WAIT_CYC() + TIMEOUT / 2) @(negedge clk);
        check(busy_o && !timeout_o, "R8", "still waiting mid-timeout",
              {busy_o, timeout_o}, 2'b10);
        got = 0;
        for (int i = 0; i < TIMEOUT + 50; i++) begin
            @(negedge clk);
            if (valid_o) got = 1;
            if (!busy_o) break;
        end
        check(timeout_o && !got, "R8", "timeout flag, no valid", {timeout_o, got}, 2'b10);
        check(spi_cs_n_o && rx_bits == 24, "R8", "select released after mode write only",
              rx_bits, 24);
        conv_en = 1; dev_data = 24'h123456; conv_delay = 40;
        pulse_start(1'b1);
        check(!timeout_o, "R8", "timeout cleared by start", timeout_o, 0);
        wait_valid(got, res);
        check(got && res == 24'h123456, "R8", "recovery after timeout", res, 24'h123456);
        wait_idle();

        // R9: interface recovery
        ifreset_i = 1'b1;
        @(negedge clk);
        ifreset_i = 1'b0;
        @(negedge clk);
        wait_cs_high();
        check(rx_bits == 32 && max_ones == 32, "R9", "32 ones frame", rx_bits, 32);
        cnt = 0;
        for (int i = 0; i < GUARD + 20; i++) begin
            if (!busy_o) break;
            cnt++;
            @(negedge clk);
        end
        check(cnt == GUARD + 1, "R9", "guard interval", cnt, GUARD + 1);

        // R10: recovery wins over start
        start_i = 1'b1; ifreset_i = 1'b1; width24_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; ifreset_i = 1'b0;
        @(negedge clk);
        wait_cs_high();
        check(rx_bits == 32 && max_ones == 32, "R10", "recovery chosen", rx_log[31:0], 32'hFFFFFFFF);
        wait_idle();
        check(!valid_o && !busy_o, "R10", "idle after guard", {valid_o, busy_o}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks + mon_checks, n_fail + mon_fails);
        $finish;
    end

    function automatic int MODE_WAIT_CYC();
        return 24 * 2 * CLK_DIV;
    endfunction

endmodule